// File: doc/BRIEF.md
# Loadable 64-bit Microsecond Timing-Synchronization Counter

This block keeps a free-running 64-bit count of microseconds for a wireless MAC. The count advances by one on each microsecond tick. The tick comes either from an external strobe or from an internal divider of the system clock, and a parameter picks the source. Software reaches the block over a plain 32-bit register port that has a write strobe and a read strobe.

Software sets a new count in two steps. It first places the low 32 bits in a staging register, then writes the upper 32 bits at a second address. The upper write commits the value only when the top bit of the upper staging register drops from 1 to 0. The usual sequence is therefore: write the low word, write the upper word with bit 31 set, then write the upper word again with bit 31 clear.

The running count is read back through two read-only words. Reading the low word also freezes a copy of the upper word, so a following read of the upper word matches the low word even if a carry happened between the two reads.

Top module: `tsf_timer_top`

## Requirements
- R1: A synchronous reset clears the counter, both staging registers and the frozen upper-word copy to zero. Reads of offset 0 and offset 1 after reset return 0.
- R2: In external-tick mode the counter rises by exactly one for each clock cycle in which `ext_tick_i` is high. With no tick and no load, the counter holds its value.
- R3: In divider mode (`USE_EXT_TICK` = 0) the counter rises by one every `PRESCALE` clock cycles, and `ext_tick_i` has no effect.
- R4: A write to offset 0 only stores the low staging word. It never changes the running count.
- R5: A write to offset 1 whose bit 31 is 0, while the stored bit 31 of the upper staging register is 1, loads the counter with {written word, low staging word} at that clock edge. No tick is added in that cycle.
- R6: A write to offset 1 that does not form a 1-to-0 transition of bit 31 (0 to 0, 0 to 1, or 1 to 1) leaves the running count unchanged.
- R7: Reset has priority over a load that is requested in the same cycle.
- R8: A read strobe at offset 0 returns the counter's low 32 bits on `rd_data_o` in the next cycle and freezes the upper 32 bits. A later read at offset 1 returns that frozen word, even if the counter has carried into the upper word in between.
- R9: A carry out of the low word increments the upper word, including the carry that sets bit 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ext_tick_i | input | 1 | External 1 µs tick strobe (used when USE_EXT_TICK=1) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write offset: 0 = low staging word, 1 = upper staging word |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Read offset: 0 = running low word, 1 = frozen upper word |
| rd_data_o | output | 32 | Read data, valid the cycle after the read strobe |

## Verification
The assertions assume that a load can arrive in the same cycle as a tick, that a write strobe carries one offset per cycle, and that reset is held for at least one clock edge. The stimulus drives every strobe for a whole cycle starting at a falling clock edge. A load is always built from a write with bit 31 set followed by a write with bit 31 clear. Ticks are pulsed only in the cycles where the bench counts them, so each expected count follows directly from the stimulus.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
    localparam int WORD_W = 32;
    localparam int TSF_W  = 2 * WORD_W;
    localparam int OFS_LO = 0;
    localparam int OFS_HI = 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [TSF_W-1:0]  tsf_t;

    typedef struct packed {
        logic  en;
        logic  sel_lo;
        logic  sel_hi;
        word_t data;
    } wr_req_t;

    typedef struct packed {
        logic en;
        logic sel_lo;
        logic sel_hi;
    } rd_req_t;

    function automatic logic msb_falls(logic old_msb, word_t new_word);
        return old_msb & ~new_word[WORD_W-1];
    endfunction
endpackage

// File: rtl/tsf_tick_gen.sv
module tsf_tick_gen #(
    parameter bit USE_EXT_TICK = 1'b0,
    parameter int PRESCALE     = 100
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ext_tick_i,
    output logic tick_o
);
    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

    logic div_tick;

    generate
        if (PRESCALE > 1) begin : g_div
            logic [PS_W-1:0] div_q;
            always_ff @(posedge clk_i) begin
                if (rst_i)
                    div_q <= '0;
                else if (div_q == PS_LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end
            assign div_tick = (div_q == PS_LAST);

            // Divider strobes are never back to back (R3)
            assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (rst_i)
                div_tick |=> !div_tick);
        end else begin : g_nodiv
            logic unused_q;
            always_ff @(posedge clk_i) unused_q <= rst_i;
            assign div_tick = 1'b1 | unused_q;
        end
    endgenerate

    assign tick_o = USE_EXT_TICK ? ext_tick_i : div_tick;
endmodule

// File: rtl/tsf_stage_regs.sv
module tsf_stage_regs
    import tsf_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  wr_req_t req_i,
    output logic    load_o,
    output tsf_t    load_val_o
);
    word_t lo_q;
    logic  hi_msb_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            lo_q     <= '0;
            hi_msb_q <= 1'b0;
        end else if (req_i.en) begin
            if (req_i.sel_lo) lo_q     <= req_i.data;
            if (req_i.sel_hi) hi_msb_q <= req_i.data[WORD_W-1];
        end
    end

    assign load_o     = req_i.en & req_i.sel_hi & msb_falls(hi_msb_q, req_i.data);
    assign load_val_o = {req_i.data, lo_q};

    // A low-word write never requests a load (R4)
    assert_lo_write_no_load_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i.en && req_i.sel_lo && !req_i.sel_hi) |-> !load_o);

    // A load is only ever preceded by a stored upper MSB of one (R6)
    assert_load_needs_armed_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        load_o |-> (hi_msb_q && !req_i.data[WORD_W-1]));
endmodule

// File: rtl/tsf_counter.sv
module tsf_counter
    import tsf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic load_i,
    input  tsf_t load_val_i,
    output tsf_t cnt_o
);
    tsf_t cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (tick_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // The loaded value appears untouched by a simultaneous tick (R5)
    assert_load_exact_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (cnt_o == $past(load_val_i)));

    // One tick moves the count by exactly one, carrying across words (R2, R9)
    assert_step_one_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !load_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

    // No tick and no load means the count holds (R2)
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !load_i) |=> $stable(cnt_o));
endmodule

// File: rtl/tsf_read_port.sv
module tsf_read_port
    import tsf_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  rd_req_t req_i,
    input  tsf_t    cnt_i,
    output word_t   rd_data_o
);
    word_t hi_snap_q;
    word_t rd_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_snap_q <= '0;
            rd_q      <= '0;
        end else if (req_i.en) begin
            if (req_i.sel_lo) begin
                rd_q      <= cnt_i[WORD_W-1:0];
                hi_snap_q <= cnt_i[TSF_W-1:WORD_W];
            end else if (req_i.sel_hi) begin
                rd_q <= hi_snap_q;
            end else begin
                rd_q <= '0;
            end
        end
    end

    assign rd_data_o = rd_q;

    // Frozen upper word only changes on a low-word read (R8)
    assert_snap_stable_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(req_i.en && req_i.sel_lo) |=> $stable(hi_snap_q));
endmodule

// File: rtl/tsf_timer_top.sv
module tsf_timer_top
    import tsf_pkg::*;
#(
    parameter bit USE_EXT_TICK = 1'b0,
    parameter int PRESCALE     = 100,
    parameter int ADDR_W       = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ext_tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o
);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(OFS_LO);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(OFS_HI);

    wr_req_t wr_req;
    rd_req_t rd_req;
    logic    tick;
    logic    load;
    tsf_t    load_val;
    tsf_t    cnt;

    assign wr_req = '{en: wr_en_i, sel_lo: (wr_addr_i == A_LO),
                      sel_hi: (wr_addr_i == A_HI), data: wr_data_i};
    assign rd_req = '{en: rd_en_i, sel_lo: (rd_addr_i == A_LO),
                      sel_hi: (rd_addr_i == A_HI)};

    tsf_tick_gen #(.USE_EXT_TICK(USE_EXT_TICK), .PRESCALE(PRESCALE)) u_tick (
        .clk_i(clk_i), .rst_i(rst_i), .ext_tick_i(ext_tick_i), .tick_o(tick));

    tsf_stage_regs u_stage (
        .clk_i(clk_i), .rst_i(rst_i), .req_i(wr_req),
        .load_o(load), .load_val_o(load_val));

    tsf_counter u_cnt (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
        .load_i(load), .load_val_i(load_val), .cnt_o(cnt));

    tsf_read_port u_rd (
        .clk_i(clk_i), .rst_i(rst_i), .req_i(rd_req),
        .cnt_i(cnt), .rd_data_o(rd_data_o));

    // A low-word staging write leaves the running count alone (R4)
    assert_lo_write_keeps_cnt_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_addr_i == A_LO && !tick) |=> $stable(cnt));
endmodule

// File: tb/tsf_timer_top_tb.sv
module tsf_timer_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;

    logic        p_rd_en = 1'b0;
    logic [31:0] p_rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tsf_timer_top #(.USE_EXT_TICK(1'b1), .PRESCALE(100), .ADDR_W(2)) u_dut (
        .clk_i(clk), .rst_i(rst), .ext_tick_i(tick),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data));

    tsf_timer_top #(.USE_EXT_TICK(1'b0), .PRESCALE(5), .ADDR_W(2)) u_pre (
        .clk_i(clk), .rst_i(rst), .ext_tick_i(1'b1),
        .wr_en_i(1'b0), .wr_addr_i(2'd0), .wr_data_i(32'd0),
        .rd_en_i(p_rd_en), .rd_addr_i(2'd0), .rd_data_o(p_rd_data));

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [7:0]  nticks;
        logic [31:0] exp_lo;
        logic [31:0] exp_hi;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{lo: 32'h0000_0010, hi: 32'h0000_0001, nticks: 8'd5, exp_lo: 32'h0000_0015, exp_hi: 32'h0000_0001},
        '{lo: 32'hFFFF_FFFE, hi: 32'h0000_00AB, nticks: 8'd3, exp_lo: 32'h0000_0001, exp_hi: 32'h0000_00AC},
        '{lo: 32'h1234_5678, hi: 32'h7FFF_FFFF, nticks: 8'd0, exp_lo: 32'h1234_5678, exp_hi: 32'h7FFF_FFFF},
        '{lo: 32'hFFFF_FFFF, hi: 32'h7FFF_FFFF, nticks: 8'd1, exp_lo: 32'h0000_0000, exp_hi: 32'h8000_0000}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load64(input logic [31:0] hi, input logic [31:0] lo);
        wr(2'd0, lo);
        wr(2'd1, hi | 32'h8000_0000);
        wr(2'd1, hi & 32'h7FFF_FFFF);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(2'd0, a); check("R1 low after reset", a, 32'h0);
        rd(2'd1, a); check("R1 high after reset", a, 32'h0);

        // R2, R5, R9: vector table
        foreach (VECS[i]) begin
            load64(VECS[i].hi, VECS[i].lo);
            pulse(int'(VECS[i].nticks));
            rd(2'd0, a); check("R2/R9 vector low", a, VECS[i].exp_lo);
            rd(2'd1, a); check("R2/R9 vector high", a, VECS[i].exp_hi);
        end

        // R2: no tick means hold
        load64(32'h0000_0002, 32'h0000_0100);
        repeat (10) @(negedge clk);
        rd(2'd0, a); check("R2 hold without tick", a, 32'h0000_0100);

        // R4: low staging write does not disturb count
        wr(2'd0, 32'hDEAD_BEEF);
        rd(2'd0, a); check("R4 low write no reload low", a, 32'h0000_0100);
        rd(2'd1, a); check("R4 low write no reload high", a, 32'h0000_0002);

        // R6: non-falling upper writes do not load
        wr(2'd1, 32'h0000_0009);
        rd(2'd0, a); check("R6 0->0 no load", a, 32'h0000_0100);
        wr(2'd1, 32'h8000_0009);
        rd(2'd0, a); check("R6 0->1 no load", a, 32'h0000_0100);
        wr(2'd1, 32'h8000_0003);
        rd(2'd0, a); rd(2'd1, b);
        check("R6 1->1 no load low", a, 32'h0000_0100);
        check("R6 1->1 no load high", b, 32'h0000_0002);
        wr(2'd1, 32'h0000_0003);
        rd(2'd0, a); rd(2'd1, b);
        check("R5 falling edge loads low", a, 32'hDEAD_BEEF);
        check("R5 falling edge loads high", b, 32'h0000_0003);

        // R5: tick in load cycle is not added
        wr(2'd0, 32'h0000_0040);
        wr(2'd1, 32'h8000_0007);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0000_0007; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(2'd0, a); check("R5 no increment on load cycle", a, 32'h0000_0040);

        // R8: coherent upper word across a carry
        load64(32'h0000_0005, 32'hFFFF_FFFF);
        rd(2'd0, a); check("R8 low before carry", a, 32'hFFFF_FFFF);
        pulse(1);
        rd(2'd1, b); check("R8 frozen high after carry", b, 32'h0000_0005);
        rd(2'd0, a); rd(2'd1, b);
        check("R8 fresh low", a, 32'h0000_0000);
        check("R8 fresh high", b, 32'h0000_0006);

        // R3: divider mode, 50 clocks -> 10 increments, ext tick ignored
        @(negedge clk); p_rd_en = 1'b1;
        @(negedge clk); p_rd_en = 1'b0; a = p_rd_data;
        repeat (48) @(negedge clk);
        p_rd_en = 1'b1;
        @(negedge clk); p_rd_en = 1'b0; b = p_rd_data;
        check("R3 divider rate", b - a, 32'd10);

        // R7: reset wins over a same-cycle load
        wr(2'd0, 32'h0000_1234);
        wr(2'd1, 32'h8000_0055);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h0000_0055;
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        rd(2'd0, a); rd(2'd1, b);
        check("R7 reset over load low", a, 32'h0);
        check("R7 reset over load high", b, 32'h0);
        // R1: reset cleared the armed upper MSB, so MSB-clear write alone does nothing
        wr(2'd1, 32'h0000_0055);
        rd(2'd0, a); check("R1 staging cleared by reset", a, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule